// File: doc/BRIEF.md
# General-Purpose I/O Bank with Grouped Interrupts

This block is a 32-line general-purpose I/O bank. A small register interface configures it. For each pin, software sets an output value, a direction, a blink enable and an input polarity. Every pin that is configured as an output drives its stored value, and that value can toggle at a rate set by a divider. Every pin passes through a two-stage synchronizer and then through its polarity inversion. The result is readable as a corrected input word.

The corrected input feeds two interrupt paths. The level path uses the corrected input directly, gated by a level mask. The edge path latches rising transitions of the corrected input into a sticky cause word, gated by an edge mask. Software acknowledges a pin by writing a word that holds zero at the bits to clear and one everywhere else. Per pin, the two masked causes are combined. Each run of eight pins is then reduced onto one of four upstream interrupt lines.

The register interface has no handshake. A write takes effect at the clock edge where the write enable is high. Read data is registered, so it reflects the address presented one cycle earlier.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads zero and all four interrupt lines are low. Because direction is zero, all output enables are high and all pins drive zero.
- R2: The writable registers take the full write word at the write edge. Their word offsets are: 0x00 output value, 0x04 direction, 0x08 blink enable, 0x0C polarity, 0x14 edge cause, 0x18 edge mask, 0x1C level mask. A read returns the register at the address given one cycle earlier.
- R3: Per pin, the output enable is the inverse of its direction bit (1 = input). With blink off, the pin drives its output-value bit.
- R4: Offset 0x10 returns each pin, after two synchronizer flops, XORed with its polarity bit.
- R5: A 0-to-1 change of a pin's corrected input sets that pin's edge-cause bit. The bit stays set until software clears it, including after the input falls again.
- R6: A write to the edge cause clears each bit written as 0 and leaves each bit written as 1 unchanged.
- R7: If a new rising edge arrives in the same cycle as a clear of that bit, the bit stays set.
- R8: A pin's level interrupt is its corrected-input bit ANDed with its level-mask bit. Setting the polarity bit therefore inverts which level interrupts.
- R9: A pin's edge interrupt is its cause bit ANDed with its edge-mask bit. Interrupt line g is the OR of the level and edge interrupts of pins 8g to 8g+7.
- R10: An output pin with blink enabled drives its output bit XORed with a toggle that flips every BLINK_DIV cycles. An input pin, or a pin with blink off, does not toggle.
- R11: Reads of offset 0x20 and above, or of an address whose low two bits are not zero, return zero. Writes to such addresses, and writes to 0x10, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| pin_in | input | 32 | Sampled pin levels (asynchronous) |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin output enables, 1 = drive |
| irq_grp | output | 4 | Upstream interrupt, one per group of eight pins |

## Verification
The bench times a rising input so that it reaches the cause register at exactly the edge where software writes zero to that bit. A design that lets the clear win loses the event, and the cause then reads back zero. It acknowledges one pin with an inverted one-hot word while a second pin stays pending. A design that clears on ones, or clears the whole word, leaves the wrong bits set. It lets an input fall after its edge was latched, and it flips polarity under a level mask. These steps expose a cause that follows the live input and a level path that bypasses the inversion. Finally, it counts transitions on a blinking output and on a blinking input pin, and it writes to the data-in offset, to an unaligned address and to an unmapped one. Each of these stimuli would show a leak in blink gating or in address decode.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Register index = byte offset / 4
  typedef enum logic [2:0] {
    REG_OUT   = 3'd0,
    REG_DIR   = 3'd1,
    REG_BLINK = 3'd2,
    REG_POL   = 3'd3,
    REG_DIN   = 3'd4,
    REG_CAUSE = 3'd5,
    REG_EMASK = 3'd6,
    REG_LMASK = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic              we,
  input  logic [NPINS-1:0]  din_word,
  input  logic [NPINS-1:0]  cause_word,
  output logic [NPINS-1:0]  rdata,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  blink_q,
  output logic [NPINS-1:0]  pol_q,
  output logic [NPINS-1:0]  emask_q,
  output logic [NPINS-1:0]  lmask_q,
  output logic              cause_clr
);
  localparam int HI_W = ADDR_W - 5;

  logic     hit;
  reg_idx_e idx;
  logic [NPINS-1:0] out_d, dir_d, blink_d, pol_d, emask_d, lmask_d, rdata_d;

  assign hit       = (addr[ADDR_W-1:5] == HI_W'(0)) && (addr[1:0] == 2'b00);
  assign idx       = reg_idx_e'(addr[4:2]);
  assign cause_clr = we && hit && (idx == REG_CAUSE);

  always_comb begin
    out_d   = out_q;
    dir_d   = dir_q;
    blink_d = blink_q;
    pol_d   = pol_q;
    emask_d = emask_q;
    lmask_d = lmask_q;
    if (we && hit) begin
      unique case (idx)
        REG_OUT:   out_d   = wdata;
        REG_DIR:   dir_d   = wdata;
        REG_BLINK: blink_d = wdata;
        REG_POL:   pol_d   = wdata;
        REG_EMASK: emask_d = wdata;
        REG_LMASK: lmask_d = wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    rdata_d = '0;
    if (hit) begin
      unique case (idx)
        REG_OUT:   rdata_d = out_q;
        REG_DIR:   rdata_d = dir_q;
        REG_BLINK: rdata_d = blink_q;
        REG_POL:   rdata_d = pol_q;
        REG_DIN:   rdata_d = din_word;
        REG_CAUSE: rdata_d = cause_word;
        REG_EMASK: rdata_d = emask_q;
        REG_LMASK: rdata_d = lmask_q;
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= '0;
      dir_q   <= '0;
      blink_q <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
      rdata   <= '0;
    end else begin
      out_q   <= out_d;
      dir_q   <= dir_d;
      blink_q <= blink_d;
      pol_q   <= pol_d;
      emask_q <= emask_d;
      lmask_q <= lmask_d;
      rdata   <= rdata_d;
    end
  end

  assert_out_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && hit && idx == REG_OUT) |=> (out_q == $past(wdata)));

  assert_reset_masks_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (emask_q == '0 && lmask_q == '0));
endmodule

// File: rtl/gpio_edge_latch.sv
module gpio_edge_latch #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_in,
  input  logic [NPINS-1:0] pol,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_keep,
  output logic [NPINS-1:0] din,
  output logic [NPINS-1:0] cause
);
  logic [NPINS-1:0] sync1_q, sync2_q, prev_q;
  logic [NPINS-1:0] rise, cause_d;

  assign din     = sync2_q ^ pol;
  assign rise    = din & ~prev_q;
  assign cause_d = (cause & (clr_we ? clr_keep : '1)) | rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
      cause   <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= din;
      cause   <= cause_d;
    end
  end

  assert_cause_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_we |=> ((cause & $past(cause)) == $past(cause)));

  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && rise == '0) |=> ((cause & ~$past(cause & clr_keep)) == '0));

  assert_edge_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((cause & $past(rise)) == $past(rise)));
endmodule

// File: rtl/gpio_blink_div.sv
module gpio_blink_div #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic tog
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap, tog_d;

  assign wrap  = (cnt_q == LAST);
  assign cnt_d = wrap ? '0 : cnt_q + 1'b1;
  assign tog_d = wrap ? ~tog : tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tog   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tog   <= tog_d;
    end
  end

  assert_cnt_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/gpio_irq_reduce.sv
module gpio_irq_reduce #(
  parameter int NPINS = 32,
  parameter int GRP_W = 8,
  localparam int NGRP = NPINS / GRP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] din,
  input  logic [NPINS-1:0] cause,
  input  logic [NPINS-1:0] emask,
  input  logic [NPINS-1:0] lmask,
  output logic [NGRP-1:0]  irq
);
  logic [NPINS-1:0] pend;
  assign pend = (din & lmask) | (cause & emask);

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign irq[g] = |pend[g*GRP_W +: GRP_W];
  end

  assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (emask == '0 && lmask == '0) |-> (irq == '0));
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank #(
  parameter int NPINS     = 32,
  parameter int GRP_W     = 8,
  parameter int ADDR_W    = 8,
  parameter int BLINK_DIV = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [NPINS-1:0]         bus_wdata,
  input  logic                     bus_we,
  output logic [NPINS-1:0]         bus_rdata,
  input  logic [NPINS-1:0]         pin_in,
  output logic [NPINS-1:0]         pin_out,
  output logic [NPINS-1:0]         pin_oe,
  output logic [NPINS/GRP_W-1:0]   irq_grp
);
  logic rst_s1_q, rst_s2_q;
  logic [NPINS-1:0] out_q, dir_q, blink_q, pol_q, emask_q, lmask_q;
  logic [NPINS-1:0] din, cause;
  logic             cause_clr, tog;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  gpio_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst_n(rst_s2_q), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .din_word(din), .cause_word(cause), .rdata(bus_rdata),
    .out_q(out_q), .dir_q(dir_q), .blink_q(blink_q), .pol_q(pol_q),
    .emask_q(emask_q), .lmask_q(lmask_q), .cause_clr(cause_clr)
  );

  gpio_edge_latch #(.NPINS(NPINS)) i_edge (
    .clk(clk), .rst_n(rst_s2_q), .pin_in(pin_in), .pol(pol_q),
    .clr_we(cause_clr), .clr_keep(bus_wdata), .din(din), .cause(cause)
  );

  gpio_blink_div #(.DIV(BLINK_DIV)) i_blink (
    .clk(clk), .rst_n(rst_s2_q), .tog(tog)
  );

  gpio_irq_reduce #(.NPINS(NPINS), .GRP_W(GRP_W)) i_irq (
    .clk(clk), .rst_n(rst_s2_q), .din(din), .cause(cause),
    .emask(emask_q), .lmask(lmask_q), .irq(irq_grp)
  );

  assign pin_oe  = ~dir_q;
  assign pin_out = out_q ^ ({NPINS{tog}} & blink_q & ~dir_q);

  assert_oe_dir_R3: assert property (@(posedge clk) disable iff (!rst_s2_q)
    (bus_we && bus_addr == ADDR_W'(4)) |=> (pin_oe == ~$past(bus_wdata)));
endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic [3:0]  irq_grp;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  gpio_irq_bank #(.BLINK_DIV(DIV)) i_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_grp(irq_grp)
  );

  // {polarity, pins, expected data-in}
  localparam logic [95:0] VEC [4] = '{
    {32'h0000_0000, 32'hA5A5_0F0F, 32'hA5A5_0F0F},
    {32'hFFFF_FFFF, 32'h0000_0000, 32'hFFFF_FFFF},
    {32'h0000_FFFF, 32'h1234_5678, 32'h1234_A987},
    {32'hF0F0_F0F0, 32'h0F0F_0F0F, 32'hFFFF_FFFF}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic count_toggles(input int bitn, output int n);
    logic last;
    n = 0;
    @(negedge clk);
    last = pin_out[bitn];
    for (int k = 0; k < 8 * DIV; k++) begin
      @(negedge clk);
      if (pin_out[bitn] !== last) n++;
      last = pin_out[bitn];
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0; pin_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(8'(a * 4), v);
      chk($sformatf("R1 reset read offset %0d", a * 4), v, 32'h0);
    end
    chk("R1 reset irq", {28'h0, irq_grp}, 32'h0);
    chk("R1 reset oe", pin_oe, 32'hFFFF_FFFF);
    chk("R1 reset out", pin_out, 32'h0);

    // R2 readback
    wr(8'h00, 32'hA5A5_5A5A);
    wr(8'h04, 32'h0F0F_00FF);
    wr(8'h08, 32'h1234_5678);
    wr(8'h0C, 32'h8000_0001);
    wr(8'h18, 32'h0000_FFFF);
    wr(8'h1C, 32'hFFFF_0000);
    rd(8'h00, v); chk("R2 out", v, 32'hA5A5_5A5A);
    rd(8'h04, v); chk("R2 dir", v, 32'h0F0F_00FF);
    rd(8'h08, v); chk("R2 blink", v, 32'h1234_5678);
    rd(8'h0C, v); chk("R2 pol", v, 32'h8000_0001);
    rd(8'h18, v); chk("R2 emask", v, 32'h0000_FFFF);
    rd(8'h1C, v); chk("R2 lmask", v, 32'hFFFF_0000);
    wr(8'h08, 32'h0); wr(8'h0C, 32'h0); wr(8'h18, 32'h0); wr(8'h1C, 32'h0);
    wr(8'h14, 32'h0);
    rd(8'h14, v); chk("R2 cause cleared", v, 32'h0);

    // R3 direction and drive
    @(negedge clk);
    chk("R3 oe", pin_oe, 32'hF0F0_FF00);
    chk("R3 out", pin_out, 32'hA5A5_5A5A);

    // R4 polarity vectors
    for (int i = 0; i < 4; i++) begin
      wr(8'h0C, VEC[i][95:64]);
      pins(VEC[i][63:32]);
      rd(8'h10, v);
      chk($sformatf("R4 vector %0d", i), v, VEC[i][31:0]);
    end
    wr(8'h10, 32'h0);
    rd(8'h10, v); chk("R11 data-in write ignored", v, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h0);
    pins(32'h0);
    wr(8'h14, 32'h0);

    // R5 latch and hold
    pins(32'h0000_0008);
    rd(8'h14, v); chk("R5 rise sets", v, 32'h0000_0008);
    pins(32'h0);
    rd(8'h14, v); chk("R5 held after fall", v, 32'h0000_0008);

    // R6 acknowledge single pin
    pins(32'h0010_0000);
    rd(8'h14, v); chk("R6 two pending", v, 32'h0010_0008);
    wr(8'h14, ~32'h0010_0000);
    rd(8'h14, v); chk("R6 one-pin ack", v, 32'h0000_0008);
    wr(8'h14, 32'h0);
    rd(8'h14, v); chk("R6 clear all", v, 32'h0);
    pins(32'h0);

    // R7 edge coincides with clear
    pins(32'h0000_0020);
    pins(32'h0);
    rd(8'h14, v); chk("R7 precondition", v, 32'h0000_0020);
    @(negedge clk); pin_in = 32'h0000_0020;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 8'h14; bus_wdata = 32'h0; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
    rd(8'h14, v); chk("R7 edge wins", v, 32'h0000_0020);
    wr(8'h14, 32'h0);
    rd(8'h14, v); chk("R7 later clear", v, 32'h0);
    pins(32'h0);

    // R8 level path
    pins(32'h0000_0200);
    wr(8'h1C, 32'h0000_0200);
    @(negedge clk); chk("R8 level high", {28'h0, irq_grp}, 32'h2);
    wr(8'h0C, 32'h0000_0200);
    @(negedge clk); chk("R8 polarity inverts level", {28'h0, irq_grp}, 32'h0);
    wr(8'h1C, 32'h0); wr(8'h0C, 32'h0);
    pins(32'h0);
    wr(8'h14, 32'h0);

    // R9 edge path and grouping
    wr(8'h18, 32'h4000_0080);
    pins(32'h4000_0000);
    chk("R9 group 3", {28'h0, irq_grp}, 32'h8);
    pins(32'h4000_0080);
    chk("R9 groups 3 and 0", {28'h0, irq_grp}, 32'h9);
    pins(32'h0);
    chk("R9 latched after fall", {28'h0, irq_grp}, 32'h9);
    wr(8'h18, 32'h0);
    @(negedge clk); chk("R9 masked", {28'h0, irq_grp}, 32'h0);
    wr(8'h14, 32'h0);

    // R10 blink
    wr(8'h04, 32'h0000_0002);
    wr(8'h00, 32'h0000_0001);
    wr(8'h08, 32'h0000_0003);
    count_toggles(0, n); chk("R10 output blinks", 32'(n), 32'd8);
    count_toggles(1, n); chk("R10 input pin steady", 32'(n), 32'd0);
    wr(8'h08, 32'h0);
    count_toggles(0, n); chk("R10 blink off steady", 32'(n), 32'd0);
    @(negedge clk); chk("R10 value after blink off", pin_out & 32'h1, 32'h1);

    // R11 undefined addresses
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R11 unmapped read", v, 32'h0);
    wr(8'h03, 32'h0);
    rd(8'h01, v); chk("R11 unaligned read", v, 32'h0);
    rd(8'h00, v); chk("R11 out untouched", v, 32'h0000_0001);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule